// File: doc/BRIEF.md
# Byte-Steered DAC Code Register with Output Override

This block assembles a 12-bit converter code from an 8-bit host bus. The host writes the upper and lower byte separately, selecting each with its own active-low byte select and qualifying every access with an active-low write strobe. The assembled word is held in an input register. It moves into the DAC register either during the same access, when the active-low load input is also low, or through a separate access that asserts only load. The common sequence is three accesses: upper byte, lower byte, then a load-only access. The DAC output changes only once, after the whole word is present.

A mode pin and a control pin work together. With the mode pin high, the control pin picks how the bytes are packed into the word: left-justified or right-justified. With the mode pin low, the code presented to the converter is forced to all zeros or all ones. The stored DAC register is not changed by this, and the output returns to the stored code once the mode pin goes high again. Every host input is brought into the clock domain through a register pipeline. An access takes effect when the synchronized write strobe rises.

Top module: `dacb_byte_dac`

## Requirements
- R1: After reset, the input word, the DAC word and the output code are all zero.
- R2: An access with write low, lower-byte select low, upper-byte select high and load high changes only the lower part of the input word. In left-justified packing, bus[7:4] go to word bits 3..0.
- R3: An access with the upper-byte select low and the lower-byte select high changes only the upper part of the input word. In left-justified packing, bus[7:0] go to word bits 11..4.
- R4: When a byte access also has load low, the DAC word receives the input word value that already includes the new byte.
- R5: An access with both byte selects high and load low copies the input word into the DAC word and ignores the bus.
- R6: While write is held high, no change of the selects, load or bus alters the input word or the DAC word.
- R7: With the mode pin low, the output code is 0x000 when control is 0 and 0xFFF when control is 1. The DAC word is unchanged, and the output follows the DAC word again once the mode pin is high. The output code differs from the DAC word only while the mode pin is low.
- R8: With the mode pin high and control 1 (right-justified packing), an upper-byte access puts bus[3:0] into word bits 11..8 and a lower-byte access puts bus[7:0] into word bits 7..0. With control 0, packing is left-justified.
- R9: The registers update on the third clock edge after the write strobe rises, exactly once per access, and not earlier.
- R10: An access with both byte selects low writes both parts of the word from the same bus value, using the current packing.
- R11: An access made while the mode pin is low uses left-justified packing.
- R12: In a three-access update (upper byte, lower byte, load-only), the DAC word keeps its old value until the load-only access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe; the access commits on its rising edge |
| cs_hi_n | input | 1 | Active-low upper-byte select |
| cs_lo_n | input | 1 | Active-low lower-byte select |
| ld_n | input | 1 | Active-low load of the DAC word |
| fmt_n | input | 1 | Mode pin: high selects packing, low forces the output |
| ctrl | input | 1 | Packing choice or forced level, depending on the mode pin |
| bus | input | 8 | Host data byte |
| dac_code | output | 12 | Code presented to the converter |
| in_word | output | 12 | Held input word |
| dac_word | output | 12 | Held DAC word |

## Verification
The hardest case to reach is a byte write combined with a load in the same access. The DAC word must then take the merged value, not the stale one. The stimulus table reaches this by first loading a known word and then writing a single byte with load low, under both packings, so that the stale and merged values differ in the checked nibble. A second hard case is a write made during the override. The bench makes it while the output is forced to all ones, then releases the override and checks that the new, left-packed code appears at the output.

// File: rtl/dacb_pkg.sv
package dacb_pkg;
  typedef enum logic {
    PACK_LEFT  = 1'b0,
    PACK_RIGHT = 1'b1
  } pack_e;

  typedef struct packed {
    logic cs_hi_n;
    logic cs_lo_n;
    logic ld_n;
    logic fmt_n;
    logic ctrl;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dacb_sync_pipe.sv
module dacb_sync_pipe #(
  parameter int W = 1,
  parameter int DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/dacb_steer.sv
module dacb_steer
  import dacb_pkg::*;
#(
  parameter int DAC_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  ctl_t             ctl,
  input  logic [BUS_W-1:0] bus,
  output logic [DAC_W-1:0] in_q,
  output logic [DAC_W-1:0] dac_q
);
  localparam int LO_W = DAC_W - BUS_W;

  pack_e             pack;
  logic [DAC_W-1:0]  in_d;
  logic [DAC_W-1:0]  dac_d;
  logic              in_en;
  logic              dac_en;

  always_comb begin
    pack = (ctl.fmt_n && ctl.ctrl) ? PACK_RIGHT : PACK_LEFT;
    in_d = in_q;
    if (!ctl.cs_hi_n) begin
      if (pack == PACK_LEFT) in_d[DAC_W-1 -: BUS_W] = bus;
      else                   in_d[DAC_W-1 -: LO_W]  = bus[LO_W-1:0];
    end
    if (!ctl.cs_lo_n) begin
      if (pack == PACK_LEFT) in_d[LO_W-1:0]  = bus[BUS_W-1 -: LO_W];
      else                   in_d[BUS_W-1:0] = bus;
    end
    in_en  = commit && !(ctl.cs_hi_n && ctl.cs_lo_n);
    dac_en = commit && !ctl.ld_n;
    dac_d  = in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_q <= '0;
    else if (in_en) in_q <= in_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dac_q <= '0;
    else if (dac_en) dac_q <= dac_d;
  end

  p_hold_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> in_q == $past(in_q));

  p_hold_dac_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit || ctl.ld_n) |=> dac_q == $past(dac_q));

  p_merge_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !ctl.ld_n) |=> dac_q == in_q);
endmodule

// File: rtl/dacb_override.sv
module dacb_override #(
  parameter int DAC_W = 12
) (
  input  logic             ovr_n,
  input  logic             level,
  input  logic [DAC_W-1:0] dac_q,
  output logic [DAC_W-1:0] code
);
  always_comb begin
    if (!ovr_n) code = {DAC_W{level}};
    else        code = dac_q;
  end
endmodule

// File: rtl/dacb_byte_dac.sv
module dacb_byte_dac
  import dacb_pkg::*;
#(
  parameter int DAC_W = 12,
  parameter int BUS_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             cs_hi_n,
  input  logic             cs_lo_n,
  input  logic             ld_n,
  input  logic             fmt_n,
  input  logic             ctrl,
  input  logic [BUS_W-1:0] bus,
  output logic [DAC_W-1:0] dac_code,
  output logic [DAC_W-1:0] in_word,
  output logic [DAC_W-1:0] dac_word
);
  localparam int BUNDLE_W = CTL_W + BUS_W;
  localparam logic [BUNDLE_W-1:0] BUNDLE_RST = {{CTL_W{1'b1}}, {BUS_W{1'b0}}};

  ctl_t                ctl_in;
  ctl_t                ctl_s;
  logic [BUS_W-1:0]    bus_s;
  logic [BUNDLE_W-1:0] bundle_s;
  logic                wr_s;
  logic                wr_d;
  logic                commit;

  assign ctl_in = '{cs_hi_n: cs_hi_n, cs_lo_n: cs_lo_n, ld_n: ld_n,
                    fmt_n: fmt_n, ctrl: ctrl};

  dacb_sync_pipe #(.W(1), .DEPTH(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .d(wr_n), .q(wr_s)
  );

  dacb_sync_pipe #(.W(BUNDLE_W), .DEPTH(SYNC_STAGES + 1), .RST_VAL(BUNDLE_RST))
    u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({ctl_in, bus}), .q(bundle_s)
  );

  assign ctl_s = ctl_t'(bundle_s[BUNDLE_W-1 -: CTL_W]);
  assign bus_s = bundle_s[BUS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_d <= 1'b1;
    else        wr_d <= wr_s;
  end

  assign commit = wr_s && !wr_d;

  dacb_steer #(.DAC_W(DAC_W), .BUS_W(BUS_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .commit(commit), .ctl(ctl_s), .bus(bus_s),
    .in_q(in_word), .dac_q(dac_word)
  );

  dacb_override #(.DAC_W(DAC_W)) u_ovr (
    .ovr_n(ctl_s.fmt_n), .level(ctl_s.ctrl), .dac_q(dac_word), .code(dac_code)
  );

  p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  p_code_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != dac_word) |-> !ctl_s.fmt_n);
endmodule

// File: tb/test_dacb_byte_dac.sv
module test_dacb_byte_dac;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_n, cs_hi_n, cs_lo_n, ld_n, fmt_n, ctrl;
  logic [7:0]  bus;
  logic [11:0] dac_code, in_word, dac_word;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dacb_byte_dac i_dacb_byte_dac (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .cs_hi_n(cs_hi_n),
    .cs_lo_n(cs_lo_n), .ld_n(ld_n), .fmt_n(fmt_n), .ctrl(ctrl), .bus(bus),
    .dac_code(dac_code), .in_word(in_word), .dac_word(dac_word)
  );

  // fields: cs_hi_n, cs_lo_n, ld_n, ctrl, bus[7:0], exp_in[11:0], exp_dac[11:0]
  localparam int NVEC = 10;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hAB, 12'hAB0, 12'h000}, // R3 left upper
    {1'b1, 1'b0, 1'b1, 1'b0, 8'hC7, 12'hABC, 12'h000}, // R2 left lower, R12
    {1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 12'hABC, 12'hABC}, // R5 load only, R12
    {1'b0, 1'b1, 1'b1, 1'b1, 8'h5E, 12'hEBC, 12'hABC}, // R8 right upper
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h12, 12'hE12, 12'hE12}, // R4 R8 right lower+load
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h3F, 12'hE13, 12'hE13}, // R4 left lower+load
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h96, 12'h969, 12'hE13}, // R10 both, left
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h4D, 12'hD4D, 12'hD4D}, // R10 both, right, load
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 12'h00D, 12'hD4D}, // R3 R12
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h77, 12'h00D, 12'h00D}  // R5 R12
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic hi, input logic lo, input logic ld,
                       input logic c, input logic [7:0] b);
    @(negedge clk);
    cs_hi_n = hi; cs_lo_n = lo; ld_n = ld; ctrl = c; bus = b;
    wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
  endtask

  task automatic finish_access();
    repeat (3) @(negedge clk);
    cs_hi_n = 1'b1; cs_lo_n = 1'b1; ld_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; cs_hi_n = 1'b1; cs_lo_n = 1'b1; ld_n = 1'b1;
    fmt_n = 1'b1; ctrl = 1'b0; bus = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 in_word", in_word, 12'h000);
    check("R1 dac_word", dac_word, 12'h000);
    check("R1 dac_code", dac_code, 12'h000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:24]);
      finish_access();
      check($sformatf("R2/R3/R4/R5/R8/R10/R12 vec%0d in_word", i), in_word, VEC[i][23:12]);
      check($sformatf("R4/R5/R12 vec%0d dac_word", i), dac_word, VEC[i][11:0]);
      check($sformatf("R7 vec%0d dac_code", i), dac_code, VEC[i][11:0]);
    end

    // R9: no change on the second edge after the strobe rises, change on the third
    drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h12);
    repeat (2) @(negedge clk);
    check("R9 before third edge", in_word, 12'h00D);
    @(negedge clk);
    check("R9 at third edge", in_word, 12'h12D);
    repeat (2) @(negedge clk);
    check("R9 single update", in_word, 12'h12D);
    cs_hi_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: selects, load and bus move while write stays high
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cs_hi_n = k[0]; cs_lo_n = ~k[0]; ld_n = k[1]; bus = 8'(k * 37);
    end
    cs_hi_n = 1'b1; cs_lo_n = 1'b1; ld_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 in_word", in_word, 12'h12D);
    check("R6 dac_word", dac_word, 12'h00D);

    // R7: override to zeros, ones, then release
    fmt_n = 1'b0; ctrl = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 forced zeros", dac_code, 12'h000);
    check("R7 dac_word kept", dac_word, 12'h00D);
    ctrl = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 forced ones", dac_code, 12'hFFF);

    // R11: write during override uses left packing
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hA0);
    finish_access();
    check("R11 in_word", in_word, 12'h12A);
    check("R11 dac_word", dac_word, 12'h12A);
    check("R7 still forced", dac_code, 12'hFFF);
    fmt_n = 1'b1; ctrl = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 released", dac_code, 12'h12A);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule